// File: doc/BRIEF.md
# Floating-point exponent/mantissa decomposer

This unit takes one IEEE-754 single-precision operand and splits it into a scaled mantissa, returned as a float, and an integer exponent term, returned as a 32-bit two's-complement value. Range-reduced reciprocal, square-root, reciprocal-square-root and logarithm sequences use these two results. The mode chooses how the split is scaled. The operand is read as m·2^e, with m in [1,2) and e the unbiased exponent. Subnormal operands are normalised before any scaling, so they follow the same convention.

The mantissa output always keeps the sign of the operand. A zero, infinite or NaN operand is passed through on the mantissa output, and it gives an exponent term of 0. Both results are registered together with the valid strobe. The latency is one cycle. When no strobe is present, the last results are held.

Top module: `fexp_split`

## Requirements
- R1: Mode 2'b00 (reciprocal): the mantissa output is m·2^-1. Its biased exponent field [30:23] is 126, and its fraction [22:0] is the normalised fraction of the operand.
- R2: Modes 2'b01 (square root) and 2'b10 (reciprocal square root): the mantissa output has biased exponent 125 when e is even and 126 when e is odd. The normalised fraction is kept.
- R3: Mode 2'b11 (logarithm): the output is x1·2^s with x1 in [0.75,1.5). If the normalised fraction bit 22 is 0, x1 = m (exponent field 127) and s = e. If that bit is 1, x1 = m/2 (field 126) and s = e+1.
- R4: In mode 2'b00 the exponent output is −e−1.
- R5: In mode 2'b01 the exponent output is floor(e/2)+1. In mode 2'b10 it is −floor(e/2)−1. The floor rounds toward minus infinity for negative e.
- R6: A subnormal operand whose highest set fraction bit is p has e = p−149. Its fraction is shifted left by 23−p, and the bits that move above bit 22 are dropped.
- R7: A zero, infinite or NaN operand (exponent field 0 with zero fraction, or exponent field 255) gives exponent output 0 in every mode. The mantissa output is then the operand bits unchanged.
- R8: Bit 31 of the mantissa output equals bit 31 of the operand.
- R9: `out_valid` and both results appear on the first rising edge after `in_valid` is sampled high.
- R10: A cycle with `in_valid` low drives `out_valid` low on the next edge and leaves both results unchanged.
- R11: While reset is asserted, `out_valid`, `out_mant` and `out_exp` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| in_mode | input | 2 | 00 reciprocal, 01 square root, 10 reciprocal square root, 11 logarithm |
| out_valid | output | 1 | Results valid |
| out_mant | output | 32 | Scaled mantissa as a float |
| out_exp | output | 32 | Signed exponent term |

## Verification
Every biased exponent from 0 to 255 is swept against a set of fractions, in all four modes and with both signs. The sweep reaches both parities of e, which separates the two square-root scalings, and negative odd exponents, which show whether the floor is arithmetic or truncating. Fractions with bit 22 set and clear test the two sides of the log range boundary. A fraction with a single set bit, walked through all 23 positions, tests subnormal normalisation. Fractions with their low bits set then check that the shifted fraction is taken correctly. Exponent field 255 with zero and non-zero fractions, together with true zeros, covers the pass-through cases. A hold check after every operand catches results that change while the strobe is low.

// File: rtl/fexp_split.sv
module fexp_split (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_op,
  input  logic [1:0]  in_mode,
  output logic        out_valid,
  output logic [31:0] out_mant,
  output logic [31:0] out_exp
);
  localparam int FW = 23;
  localparam int EW = 8;
  localparam int XW = 10;
  localparam logic [1:0] M_RCP = 2'd0, M_SQRT = 2'd1, M_RSQ = 2'd2, M_LOG = 2'd3;

  logic [EW-1:0] bexp;
  logic [FW-1:0] frac, nfrac;
  logic          is_sub, is_special, lz_found;
  logic [4:0]    lz;
  logic signed [XW-1:0] unb, half, xexp;
  logic [EW-1:0] mexp;
  logic [31:0]   mant_n, exp_n;

  assign bexp       = in_op[30:23];
  assign frac       = in_op[22:0];
  assign is_sub     = (bexp == '0) && (frac != '0);
  assign is_special = ((bexp == '0) && (frac == '0)) || (bexp == '1);

  always_comb begin
    lz = '0;
    lz_found = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (frac[i] && !lz_found) begin
        lz = 5'(FW - 1 - i);
        lz_found = 1'b1;
      end
    end
  end

  assign nfrac = is_sub ? FW'(frac << (lz + 5'd1)) : frac;
  assign unb   = is_sub ? (-10'sd127 - $signed({5'b0, lz}))
                        : ($signed({2'b00, bexp}) - 10'sd127);
  assign half  = unb >>> 1;

  always_comb begin
    case (in_mode)
      M_RCP:  begin mexp = 8'd126; xexp = -unb - 10'sd1; end
      M_SQRT: begin mexp = unb[0] ? 8'd126 : 8'd125; xexp = half + 10'sd1; end
      M_RSQ:  begin mexp = unb[0] ? 8'd126 : 8'd125; xexp = -half - 10'sd1; end
      default: begin
        mexp = nfrac[FW-1] ? 8'd126 : 8'd127;
        xexp = nfrac[FW-1] ? unb + 10'sd1 : unb;
      end
    endcase
  end

  assign mant_n = is_special ? in_op : {in_op[31], mexp, nfrac};
  assign exp_n  = is_special ? '0 : {{(32-XW){xexp[XW-1]}}, xexp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mant  <= '0;
      out_exp   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mant <= mant_n;
        out_exp  <= exp_n;
      end
    end
  end
endmodule

module fexp_split_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_op,
  input logic [1:0]  in_mode,
  input logic        out_valid,
  input logic [31:0] out_mant,
  input logic [31:0] out_exp
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mant) && $stable(out_exp)));
  a_r8_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_mant[31] == $past(in_op[31])));
  a_r7_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((out_mant[30:23] == 8'hFF) || (out_mant[30:0] == 31'd0))) |-> (out_exp == 32'd0));
  a_r1_mant_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_mant[30:23] != 8'h00) && (out_mant[30:23] != 8'hFF))
      |-> (out_mant[30:23] inside {8'd125, 8'd126, 8'd127}));
  always @(posedge clk)
    if (!rst_n) a_r11_reset_idle: assert (!out_valid);
  wire unused_ok = &{1'b0, in_mode};
endmodule

bind fexp_split fexp_split_chk chk_i (.*);

// File: tb/fexp_split_tb.sv
`timescale 1ns/1ps
module fexp_split_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic [31:0] out_mant, out_exp;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fexp_split dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
                    .in_mode(in_mode), .out_valid(out_valid), .out_mant(out_mant),
                    .out_exp(out_exp));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_one(input logic [31:0] op, input logic [1:0] md);
    logic [7:0]  bexp = op[30:23];
    logic [22:0] f = op[22:0];
    logic [22:0] nf;
    logic [7:0]  mf;
    logic [31:0] mant_e;
    int e, fl, ee, p;
    bit special, sub;
    string rm, re;
    special = (bexp == 8'hFF) || (bexp == 8'h00 && f == '0);
    sub = (bexp == 8'h00) && (f != '0);
    e = 0; nf = f; mf = 0; ee = 0;
    if (bexp != 0) e = int'(bexp) - 127;
    else if (sub) begin
      p = 22;
      while (!f[p]) p--;
      e = p - 149;
      nf = 23'(f << (23 - p));
    end
    fl = (e >= 0) ? e / 2 : -((-e + 1) / 2);
    case (md)
      2'd0: begin mf = 8'd126; ee = -e - 1; rm = "R1"; re = "R4"; end
      2'd1: begin mf = (e & 1) ? 8'd126 : 8'd125; ee = fl + 1; rm = "R2"; re = "R5"; end
      2'd2: begin mf = (e & 1) ? 8'd126 : 8'd125; ee = -fl - 1; rm = "R2"; re = "R5"; end
      default: begin
        mf = nf[22] ? 8'd126 : 8'd127; ee = nf[22] ? e + 1 : e; rm = "R3"; re = "R3";
      end
    endcase
    mant_e = {op[31], mf, nf};
    if (special) begin mant_e = op; ee = 0; rm = "R7"; re = "R7"; end
    else if (sub) begin rm = {rm, "/R6"}; re = {re, "/R6"}; end
    @(negedge clk);
    in_op = op; in_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_op = ~op; in_mode = ~md;
    chk(out_valid === 1'b1, "R9 valid", {31'd0, out_valid}, 32'd1);
    chk(out_mant === mant_e, rm, out_mant, mant_e);
    chk($signed(out_exp) == ee, re, out_exp, 32'(ee));
    chk(out_mant[31] === op[31], "R8 sign", {31'd0, out_mant[31]}, {31'd0, op[31]});
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 valid low", {31'd0, out_valid}, 32'd0);
    chk(out_mant === mant_e && $signed(out_exp) == ee, "R10 hold", out_mant, mant_e);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [22:0] fr [7] = '{23'h000000, 23'h000001, 23'h400000, 23'h3FFFFF,
                            23'h7FFFFF, 23'h2AAAAA, 23'h555555};
    in_valid = 1'b1; in_op = 32'h3F80_0000;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 valid", {31'd0, out_valid}, 32'd0);
    chk(out_mant === 32'd0, "R11 mant", out_mant, 32'd0);
    chk(out_exp === 32'd0, "R11 exp", out_exp, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int be = 0; be < 256; be++)
      for (int k = 0; k < 7; k++)
        for (int m = 0; m < 4; m++)
          for (int s = 0; s < 2; s++)
            run_one({1'(s), 8'(be), fr[k]}, 2'(m));
    for (int bp = 0; bp < 23; bp++)
      for (int m = 0; m < 4; m++) begin
        run_one({1'b0, 8'h00, 23'(1) << bp}, 2'(m));
        run_one({1'b1, 8'h00, (23'(1) << bp) | 23'((1 << bp) - 1)}, 2'(m));
      end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule